// File: doc/BRIEF.md
# Four-Phase Handshake Clock-Domain Bridge

This block moves one multi-bit word at a time from a source clock domain to a destination clock domain that has no fixed phase or frequency relation to it. On the source side a producer offers a word with a valid/ready pair. Once a word is taken, the source controller keeps it in a holding register and raises a request line. The destination controller sees the request through a synchronizer, latches the held word into its own register and presents it with a single-cycle valid strobe. It then raises an acknowledge line, which crosses back through a synchronizer of its own.

The two lines follow a return-to-zero protocol. The source drops its request only after it sees the acknowledge. The destination drops the acknowledge only after it sees the request fall. The source takes no new word until it sees the acknowledge low again. Each transfer therefore uses four line transitions and leaves both lines low. Each domain has its own clock and its own asynchronous active-low reset. The data width and the synchronizer depth are parameters. The depth can never drop below two flip-flops.

Top module: `hs_cdc_bridge`

## Requirements
- R1: After either reset is released, both controllers are idle, `src_ready` is high and `dst_valid` is low, and `dst_valid` stays low while no word has been offered.
- R2: A word is taken on a `src_clk` edge where `src_valid` and `src_ready` are both high, and `src_ready` is low in the cycle that follows.
- R3: Every word taken is delivered on `dst_data` exactly once, unchanged and in the order taken, with `dst_data` sampled while `dst_valid` is high.
- R4: While a transfer is in flight, changes on `src_data` have no effect: the held word and the delivered word are the one that was taken.
- R5: The destination raises its acknowledge only after the word is stored in its output register and the valid strobe has been issued.
- R6: The source lowers its request only in a cycle where its synchronized acknowledge is high.
- R7: The destination lowers its acknowledge only after it has seen the request low. The source raises a new request, and raises `src_ready` again, only after the previous word has been delivered and its synchronized acknowledge is low.
- R8: A high `src_valid` while `src_ready` is low is ignored and produces no extra delivered word.
- R9: `dst_valid` is high for exactly one `dst_clk` cycle per transfer. It rises in the cycle after the capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_valid | input | 1 | Producer offers `src_data` |
| src_ready | output | 1 | Bridge idle and able to take a word |
| src_data | input | DATA_W | Word offered by the producer |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_valid | output | 1 | One-cycle strobe marking a delivered word |
| dst_data | output | DATA_W | Delivered word, held until the next delivery |

## Verification
The hardest case to reach from the ports is a producer that keeps `src_valid` high and keeps changing `src_data` while a transfer is in flight. This must neither disturb the held word nor start a second transfer. The bench drives random words and random idle gaps with two clocks of unrelated period. After each acceptance it spends several source cycles writing fresh random values on `src_data` with `src_valid` still high. Later it checks that the delivered word is still the accepted one, and that `src_ready` comes back only after the delivery has been counted.

// File: rtl/hs_cdc_bridge_pkg.sv
`timescale 1ns/1ps
package hs_cdc_bridge_pkg;

    // source controller states
    typedef enum logic [1:0] {
        SRC_IDLE    = 2'd0,
        SRC_REQ     = 2'd1,
        SRC_RELEASE = 2'd2
    } src_state_e;

    // destination controller states: idle, read, acknowledge, wait for release
    typedef enum logic [1:0] {
        DST_IDLE = 2'd0,
        DST_READ = 2'd1,
        DST_ACK  = 2'd2,
        DST_WAIT = 2'd3
    } dst_state_e;

    typedef struct packed {
        src_state_e state;
        logic       req;
    } src_regs_t;

    typedef struct packed {
        dst_state_e state;
        logic       ack;
        logic       valid;
    } dst_regs_t;

endpackage

// File: rtl/hsb_sync.sv
`timescale 1ns/1ps
module hsb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    // never fewer than two flops on a crossing line
    localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

    logic [DEPTH-1:0] chain_d;
    logic [DEPTH-1:0] chain_q;

    always_comb begin
        chain_d = {chain_q[DEPTH-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[DEPTH-1];

endmodule

// File: rtl/hsb_src_ctrl.sv
`timescale 1ns/1ps
module hsb_src_ctrl
    import hs_cdc_bridge_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              ack_s,
    output logic              req_o,
    output logic [DATA_W-1:0] bus_o
);
    src_regs_t         cur_q, nxt_d;
    logic [DATA_W-1:0] bus_d, bus_q;

    assign in_ready = (cur_q.state == SRC_IDLE) && !ack_s;

    always_comb begin
        nxt_d = cur_q;
        bus_d = bus_q;
        case (cur_q.state)
            SRC_IDLE: begin
                if (in_valid && in_ready) begin
                    bus_d       = in_data;
                    nxt_d.req   = 1'b1;
                    nxt_d.state = SRC_REQ;
                end
            end
            SRC_REQ: begin
                if (ack_s) begin
                    nxt_d.req   = 1'b0;
                    nxt_d.state = SRC_RELEASE;
                end
            end
            SRC_RELEASE: begin
                if (!ack_s) nxt_d.state = SRC_IDLE;
            end
            default: begin
                nxt_d.req   = 1'b0;
                nxt_d.state = SRC_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: SRC_IDLE, req: 1'b0};
            bus_q <= '0;
        end else begin
            cur_q <= nxt_d;
            bus_q <= bus_d;
        end
    end

    // request and bus come straight from flops
    assign req_o = cur_q.req;
    assign bus_o = bus_q;

    AST_ACCEPT_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> cur_q.req); // R2
    AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.req |=> $stable(bus_q)); // R4
    AST_REQ_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cur_q.req) |-> $past(ack_s)); // R6
    AST_REQ_RISE_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.req) |-> $past(!ack_s)); // R7

endmodule

// File: rtl/hsb_dst_ctrl.sv
`timescale 1ns/1ps
module hsb_dst_ctrl
    import hs_cdc_bridge_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_s,
    input  logic [DATA_W-1:0] bus_i,
    output logic              ack_o,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    dst_regs_t         cur_q, nxt_d;
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.valid = 1'b0;
        data_d      = data_q;
        case (cur_q.state)
            DST_IDLE: begin
                if (req_s) nxt_d.state = DST_READ;
            end
            DST_READ: begin
                data_d      = bus_i;
                nxt_d.valid = 1'b1;
                nxt_d.state = DST_ACK;
            end
            DST_ACK: begin
                nxt_d.ack   = 1'b1;
                nxt_d.state = DST_WAIT;
            end
            DST_WAIT: begin
                if (!req_s) begin
                    nxt_d.ack   = 1'b0;
                    nxt_d.state = DST_IDLE;
                end
            end
            default: begin
                nxt_d.ack   = 1'b0;
                nxt_d.state = DST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '{state: DST_IDLE, ack: 1'b0, valid: 1'b0};
            data_q <= '0;
        end else begin
            cur_q  <= nxt_d;
            data_q <= data_d;
        end
    end

    assign ack_o     = cur_q.ack;
    assign out_valid = cur_q.valid;
    assign out_data  = data_q;

    AST_ACK_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.ack) |-> $past(cur_q.valid)); // R5
    AST_ACK_DROP_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cur_q.ack) |-> $past(!req_s)); // R7
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.valid |=> !cur_q.valid); // R9
    AST_VALID_NOT_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.valid |-> !cur_q.ack); // R9

endmodule

// File: rtl/hs_cdc_bridge.sv
`timescale 1ns/1ps
module hs_cdc_bridge #(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [DATA_W-1:0] src_data,
    input  logic              dst_clk,
    input  logic              dst_rst_n,
    output logic              dst_valid,
    output logic [DATA_W-1:0] dst_data
);
    logic              req_line, ack_line;
    logic              req_synced, ack_synced;
    logic [DATA_W-1:0] hold_bus;

    hsb_src_ctrl #(.DATA_W(DATA_W)) i_src (
        .clk      (src_clk),
        .rst_n    (src_rst_n),
        .in_valid (src_valid),
        .in_ready (src_ready),
        .in_data  (src_data),
        .ack_s    (ack_synced),
        .req_o    (req_line),
        .bus_o    (hold_bus)
    );

    hsb_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
        .clk     (dst_clk),
        .rst_n   (dst_rst_n),
        .async_i (req_line),
        .sync_o  (req_synced)
    );

    hsb_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
        .clk     (src_clk),
        .rst_n   (src_rst_n),
        .async_i (ack_line),
        .sync_o  (ack_synced)
    );

    hsb_dst_ctrl #(.DATA_W(DATA_W)) i_dst (
        .clk       (dst_clk),
        .rst_n     (dst_rst_n),
        .req_s     (req_synced),
        .bus_i     (hold_bus),
        .ack_o     (ack_line),
        .out_valid (dst_valid),
        .out_data  (dst_data)
    );

endmodule

// File: tb/test_hs_cdc_bridge.sv
`timescale 1ns/1ps
module test_hs_cdc_bridge;
    localparam int W = 16;

    logic         src_clk = 1'b0, dst_clk = 1'b0;
    logic         src_rst_n = 1'b0, dst_rst_n = 1'b0;
    logic         src_valid = 1'b0;
    logic [W-1:0] src_data = '0;
    logic         src_ready, dst_valid;
    logic [W-1:0] dst_data;

    int checks = 0, errors = 0;
    int sent = 0, recv = 0;
    bit finished = 1'b0;
    logic [W-1:0] exp_q[$];
    logic prev_valid = 1'b0;

    always #4.0 src_clk = ~src_clk;    // 125 MHz
    always #6.5 dst_clk = ~dst_clk;    // unrelated destination clock

    hs_cdc_bridge #(.DATA_W(W), .SYNC_STAGES(2)) i_hs_cdc_bridge (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(src_valid),
        .src_ready(src_ready), .src_data(src_data),
        .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
        .dst_valid(dst_valid), .dst_data(dst_data)
    );

    function automatic logic [W-1:0] pattern_word(input int idx);
        return W'((idx * 16'h9e37) ^ (idx << 3) ^ 16'h5a5a);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // destination monitor: R3 order and value, R9 single strobe, R8 no extra words
    always @(negedge dst_clk) begin
        if (dst_rst_n) begin
            if (dst_valid && prev_valid)
                check(1'b0, "R9 strobe longer than one cycle", 1, 0);
            if (dst_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected delivered word", dst_data, 0);
                end else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    check(dst_data == e, "R3 delivered word", dst_data, e);
                end
                recv++;
            end
            prev_valid = dst_valid;
        end
    end

    task automatic send(input logic [W-1:0] w, input int scribble);
        @(negedge src_clk);
        src_valid = 1'b1;
        src_data  = w;
        while (!src_ready) @(negedge src_clk);
        @(posedge src_clk);
        exp_q.push_back(w);
        sent++;
        @(negedge src_clk);
        check(src_ready == 1'b0, "R2 ready low after accept", src_ready, 0);
        // R4 and R8: keep valid high and churn data while busy
        for (int k = 0; k < scribble; k++) begin
            src_data  = W'($urandom);
            src_valid = 1'b1;
            check(src_ready == 1'b0, "R8 ready low while busy", src_ready, 0);
            @(negedge src_clk);
        end
        src_valid = 1'b0;
        src_data  = W'($urandom);
        while (!src_ready) @(negedge src_clk);
        // R5 R6 R7: ready returns only after the full handshake delivered the word
        check(recv == sent, "R7 ready back before delivery", recv, sent);
    endtask

    initial begin
        repeat (150000) @(posedge src_clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge src_clk);
        src_rst_n = 1'b1;
        repeat (2) @(negedge dst_clk);
        dst_rst_n = 1'b1;
        // R1 reset state
        @(negedge src_clk);
        check(src_ready == 1'b1, "R1 ready after reset", src_ready, 1);
        check(dst_valid == 1'b0, "R1 valid after reset", dst_valid, 0);
        repeat (10) @(negedge dst_clk);
        check(recv == 0, "R1 no strobe while idle", recv, 0);

        // directed corners
        send('0, 0);
        send('1, 3);
        send(16'h8001, 2);
        send('1, 0);

        // random words, gaps and data churn
        for (int i = 0; i < 40; i++) begin
            int gap;
            gap = int'($urandom_range(0, 3));
            repeat (gap) @(negedge src_clk);
            send(($urandom_range(0, 1) == 1) ? W'($urandom) : pattern_word(i),
                 int'($urandom_range(0, 3)));
        end

        repeat (20) @(negedge dst_clk);
        check(recv == sent, "R3 all words delivered", recv, sent);
        check(exp_q.size() == 0, "R8 no leftover words", exp_q.size(), 0);
        check(dst_valid == 1'b0, "R9 strobe low at rest", dst_valid, 0);
        finish_run();
    end

endmodule